// File: doc/BRIEF.md
# IR Carrier Modulation Timer Pair

This block holds two cooperating counters. The main timer is 16 bits wide. It has a programmable prescaler, a buffered period and five channels. Each channel either drives a pulse-width-modulated output or timestamps edges on its input pin. The carrier timer is 8 bits wide and has its own prescaler, period and compare value, so it produces a carrier square wave with a chosen duty.

In IR generation mode the main timer stops counting prescaled clocks. It advances once for each completed carrier period instead. The output of channel 0 is then gated with the carrier to form a modulated consumer-IR envelope, with no software work per pulse.

Software sets up and reads the block through a single-cycle register port: write strobe, 4-bit address and 16-bit data. Read data is combinational from the address.

Top module: `ir_mod_timer`

Register map, with all fields LSB-aligned:
- Address 0: main control. Bits [2:0] select the prescaler, bit 3 enables the timer and bit 4 turns on IR mode.
- Address 1: main period.
- Addresses 2 to 6: compare values for channels 0 to 4.
- Address 7: channel modes, three bits per channel, with channel i at bits [3i+2:3i].
- Address 8: carrier control. Bits [2:0] select the prescaler and bit 3 enables the carrier.
- Address 9: carrier period in [7:0] and carrier compare in [15:8].
- Address 10: capture flags. Reading returns the flags; writing a one clears that flag.
- Addresses 11 to 15: captured values for channels 0 to 4, read only.

## Requirements
- R1: After reset all outputs are low, all capture flags are zero and every captured value reads 0.
- R2: A prescaler field value s (0 to 7) divides the count rate by 2^s, so a timer with period P and divide D repeats every (P+1)*D clocks.
- R3: While enabled, the main counter runs from 0 up to the period and then wraps to 0. A PWM channel is high exactly while the counter is below its compare value: compare 0 keeps it always low, and a compare above the period keeps it always high.
- R4: A channel output is low while the main timer is disabled (control bit 3 = 0) or while that channel is in capture mode (mode bit 0 = 1).
- R5: Period and compare writes are buffered. They take effect when the counter wraps, or immediately while the timer is disabled, so the period in progress keeps its old duty.
- R6: The carrier output is high while the carrier counter is below the carrier compare value. The carrier counter wraps after reaching the carrier period and uses its own prescaler.
- R7: In IR mode the main counter advances once per carrier period, and the IR output equals channel 0 AND the carrier output. Outside IR mode the IR output stays low.
- R8: In capture mode, mode bit 1 selects rising edges and mode bit 2 selects falling edges. Both bits together capture both edges, and neither bit captures nothing. A selected edge, seen while the main timer is enabled, stores the current counter value.
- R9: A capture sets that channel's flag. Writing a one to address 10 clears only the matching flag bits. A capture in the same cycle as its clear leaves the flag set.
- R10: Edges on the input of a channel in PWM mode change neither its flag nor its captured value.
- R11: Registers at addresses 0 to 9 read back their written value (unused bits read 0), address 10 reads the flags, and addresses 11 to 15 read the captured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for reads and writes |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for regAddr |
| capIn | input | 5 | Per-channel capture inputs |
| chanOut | output | 5 | Per-channel PWM outputs |
| carOut | output | 1 | Carrier timer output |
| irOut | output | 1 | Modulated IR output |
| capFlag | output | 5 | Per-channel capture flags |

## Verification
The assertions assume that the capture inputs are already synchronous to clk, since the block has no synchronizer. They also assume that every register write is a single-cycle strobe with stable address and data. The stimulus changes capture inputs and register signals only on falling clock edges, so every change is sampled cleanly at the next rising edge. The stimulus also disables a timer before changing its period, so the buffered values reload predictably.

// File: rtl/irt_pkg.sv
package irt_pkg;
  localparam int NCH    = 5;
  localparam int CNT_W  = 16;
  localparam int CAR_W  = 8;
  localparam int PRE_W  = 3;
  localparam int ADDR_W = 4;
  localparam int MODE_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_PER   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CMP0  = 4'd2;
  localparam logic [ADDR_W-1:0] A_MODE  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CCTRL = 4'd8;
  localparam logic [ADDR_W-1:0] A_CREG  = 4'd9;
  localparam logic [ADDR_W-1:0] A_FLAG  = 4'd10;
  localparam logic [ADDR_W-1:0] A_CAP0  = 4'd11;

  typedef struct packed {
    logic           mainRun;
    logic           carRun;
    logic           irMode;
    logic           mainTick;
    logic           carTick;
    logic [NCH-1:0] flagClr;
  } strobe_t;
endpackage

// File: rtl/irt_prescaler.sv
module irt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = DIV_W'((32'd1 << sel) - 32'd1);
    tick = run && ((divCnt & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (!rstN || !run) divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end
endmodule

// File: rtl/irt_control.sv
module irt_control
  import irt_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWe,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [CNT_W-1:0]              regWdata,
  output logic [CNT_W-1:0]              regRdata,
  input  logic [NCH-1:0]                capFlag,
  input  logic [NCH-1:0][CNT_W-1:0]     capVal,
  output strobe_t                       stb,
  output logic [CNT_W-1:0]              mainPerSh,
  output logic [NCH-1:0][CNT_W-1:0]     cmpSh,
  output logic [NCH-1:0][MODE_W-1:0]    chanMode,
  output logic [CAR_W-1:0]              carPerSh,
  output logic [CAR_W-1:0]              carCmpSh
);
  logic [PRE_W+1:0]       mainCtrl;
  logic [PRE_W:0]         carCtrl;
  logic [CNT_W-1:0]       carReg;
  logic [NCH*MODE_W-1:0]  modeReg;
  logic                   mainTick;
  logic                   carTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainCtrl  <= '0;
      carCtrl   <= '0;
      carReg    <= '0;
      modeReg   <= '0;
      mainPerSh <= '0;
      cmpSh     <= '0;
    end else if (regWe) begin
      if (regAddr == A_CTRL)  mainCtrl  <= regWdata[PRE_W+1:0];
      if (regAddr == A_PER)   mainPerSh <= regWdata;
      if (regAddr == A_MODE)  modeReg   <= regWdata[NCH*MODE_W-1:0];
      if (regAddr == A_CCTRL) carCtrl   <= regWdata[PRE_W:0];
      if (regAddr == A_CREG)  carReg    <= regWdata;
      for (int i = 0; i < NCH; i++)
        if (regAddr == ADDR_W'(A_CMP0 + i)) cmpSh[i] <= regWdata;
    end
  end

  irt_prescaler #(.SEL_W(PRE_W)) u_mainPre (
    .clk(clk), .rstN(rstN), .run(mainCtrl[PRE_W]),
    .sel(mainCtrl[PRE_W-1:0]), .tick(mainTick)
  );

  irt_prescaler #(.SEL_W(PRE_W)) u_carPre (
    .clk(clk), .rstN(rstN), .run(carCtrl[PRE_W]),
    .sel(carCtrl[PRE_W-1:0]), .tick(carTick)
  );

  always_comb begin
    stb.mainRun  = mainCtrl[PRE_W];
    stb.irMode   = mainCtrl[PRE_W+1];
    stb.carRun   = carCtrl[PRE_W];
    stb.mainTick = mainTick;
    stb.carTick  = carTick;
    stb.flagClr  = (regWe && regAddr == A_FLAG) ? regWdata[NCH-1:0] : '0;
    carPerSh     = carReg[CAR_W-1:0];
    carCmpSh     = carReg[CAR_W +: CAR_W];
    for (int i = 0; i < NCH; i++)
      chanMode[i] = modeReg[i*MODE_W +: MODE_W];
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL:  regRdata = CNT_W'(mainCtrl);
      A_PER:   regRdata = mainPerSh;
      A_MODE:  regRdata = CNT_W'(modeReg);
      A_CCTRL: regRdata = CNT_W'(carCtrl);
      A_CREG:  regRdata = carReg;
      A_FLAG:  regRdata = CNT_W'(capFlag);
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (regAddr == ADDR_W'(A_CMP0 + i)) regRdata = cmpSh[i];
      if (regAddr == ADDR_W'(A_CAP0 + i)) regRdata = capVal[i];
    end
  end
endmodule

// File: rtl/irt_datapath.sv
module irt_datapath
  import irt_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       stb,
  input  logic [CNT_W-1:0]              mainPerSh,
  input  logic [NCH-1:0][CNT_W-1:0]     cmpSh,
  input  logic [NCH-1:0][MODE_W-1:0]    chanMode,
  input  logic [CAR_W-1:0]              carPerSh,
  input  logic [CAR_W-1:0]              carCmpSh,
  input  logic [NCH-1:0]                capIn,
  output logic [NCH-1:0]                chanOut,
  output logic                          carOut,
  output logic                          irOut,
  output logic [NCH-1:0]                capFlag,
  output logic [NCH-1:0][CNT_W-1:0]     capVal,
  output logic [CNT_W-1:0]              mainCnt,
  output logic [CNT_W-1:0]              mainPerAct,
  output logic [CAR_W-1:0]              carCnt,
  output logic [CAR_W-1:0]              carPerAct
);
  logic [CAR_W-1:0]          carCmpAct;
  logic [NCH-1:0][CNT_W-1:0] cmpAct;
  logic                      carWrap;
  logic                      mainStep;
  logic                      mainWrap;

  always_comb begin
    carWrap  = stb.carTick && (carCnt >= carPerAct);
    mainStep = stb.irMode ? carWrap : stb.mainTick;
    mainWrap = mainStep && (mainCnt >= mainPerAct);
  end

  // carrier counter with buffered period and compare
  always_ff @(posedge clk) begin
    if (!rstN) begin
      carCnt    <= '0;
      carPerAct <= '0;
      carCmpAct <= '0;
    end else begin
      if (!stb.carRun || carWrap) begin
        carPerAct <= carPerSh;
        carCmpAct <= carCmpSh;
      end
      if (!stb.carRun || carWrap) carCnt <= '0;
      else if (stb.carTick)       carCnt <= carCnt + 1'b1;
    end
  end

  // main counter with buffered period and compares
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainCnt    <= '0;
      mainPerAct <= '0;
      cmpAct     <= '0;
    end else begin
      if (!stb.mainRun || mainWrap) begin
        mainPerAct <= mainPerSh;
        cmpAct     <= cmpSh;
      end
      if (!stb.mainRun || mainWrap) mainCnt <= '0;
      else if (mainStep)            mainCnt <= mainCnt + 1'b1;
    end
  end

  assign carOut = stb.carRun && (carCnt < carCmpAct);
  assign irOut  = stb.irMode && chanOut[0] && carOut;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic prevIn;
    logic edgeHit;

    assign chanOut[g] = stb.mainRun && !chanMode[g][0] && (mainCnt < cmpAct[g]);
    assign edgeHit = stb.mainRun && chanMode[g][0] &&
                     ((chanMode[g][1] && capIn[g] && !prevIn) ||
                      (chanMode[g][2] && !capIn[g] && prevIn));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevIn     <= 1'b0;
        capVal[g]  <= '0;
        capFlag[g] <= 1'b0;
      end else begin
        prevIn     <= capIn[g];
        if (edgeHit) capVal[g] <= mainCnt;
        capFlag[g] <= edgeHit || (capFlag[g] && !stb.flagClr[g]);
      end
    end
  end
endmodule

// File: rtl/ir_mod_timer.sv
module ir_mod_timer
  import irt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  input  logic [NCH-1:0]    capIn,
  output logic [NCH-1:0]    chanOut,
  output logic              carOut,
  output logic              irOut,
  output logic [NCH-1:0]    capFlag
);
  strobe_t                       stb;
  logic [CNT_W-1:0]              mainPerSh;
  logic [NCH-1:0][CNT_W-1:0]     cmpSh;
  logic [NCH-1:0][MODE_W-1:0]    chanMode;
  logic [CAR_W-1:0]              carPerSh;
  logic [CAR_W-1:0]              carCmpSh;
  logic [NCH-1:0][CNT_W-1:0]     capVal;
  logic [CNT_W-1:0]              mainCnt;
  logic [CNT_W-1:0]              mainPerAct;
  logic [CAR_W-1:0]              carCnt;
  logic [CAR_W-1:0]              carPerAct;

  irt_control u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .capFlag(capFlag),
    .capVal(capVal), .stb(stb), .mainPerSh(mainPerSh), .cmpSh(cmpSh),
    .chanMode(chanMode), .carPerSh(carPerSh), .carCmpSh(carCmpSh)
  );

  irt_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .mainPerSh(mainPerSh),
    .cmpSh(cmpSh), .chanMode(chanMode), .carPerSh(carPerSh),
    .carCmpSh(carCmpSh), .capIn(capIn), .chanOut(chanOut),
    .carOut(carOut), .irOut(irOut), .capFlag(capFlag), .capVal(capVal),
    .mainCnt(mainCnt), .mainPerAct(mainPerAct), .carCnt(carCnt),
    .carPerAct(carPerAct)
  );
endmodule

// File: rtl/irt_checker.sv
module irt_checker
  import irt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [CNT_W-1:0]  regWdata,
  input logic [NCH-1:0]    capIn,
  input logic [NCH-1:0]    chanOut,
  input logic              carOut,
  input logic              irOut,
  input logic [NCH-1:0]    capFlag,
  input logic [CNT_W-1:0]  mainCnt,
  input logic [CNT_W-1:0]  mainPerAct,
  input logic [CAR_W-1:0]  carCnt,
  input logic [CAR_W-1:0]  carPerAct
);
  assert_main_in_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    mainCnt <= mainPerAct);

  assert_car_in_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    carCnt <= carPerAct);

  assert_ir_gated_R7: assert property (@(posedge clk) disable iff (!rstN)
    irOut |-> (chanOut[0] && carOut));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_flag_needs_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
      $rose(capFlag[g]) |-> ($past(capIn[g]) != $past(capIn[g], 2)));

    assert_flag_clear_by_write_R9: assert property (@(posedge clk) disable iff (!rstN)
      $fell(capFlag[g]) |-> $past(regWe && regAddr == A_FLAG && regWdata[g]));
  end
endmodule

bind ir_mod_timer irt_checker u_chk (.*);

// File: tb/ir_mod_timer_test.sv
module ir_mod_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [4:0]  capIn = '0;
  logic [4:0]  chanOut;
  logic        carOut;
  logic        irOut;
  logic [4:0]  capFlag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  ir_mod_timer uut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .capIn(capIn),
    .chanOut(chanOut), .carOut(carOut), .irOut(irOut), .capFlag(capFlag)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    regAddr = a;
    #1;
    v = int'(regRdata);
  endtask

  task automatic sample(input int sel, output bit b);
    if (sel < 5)       b = chanOut[sel];
    else if (sel == 5) b = carOut;
    else               b = irOut;
  endtask

  task automatic countHigh(input int sel, input int n, output int c);
    bit b;
    c = 0;
    repeat (n) begin
      @(negedge clk);
      sample(sel, b);
      if (b) c++;
    end
  endtask

  task automatic testReset();
    int v;
    check("R1 chanOut", int'(chanOut), 0);
    check("R1 carOut", int'(carOut), 0);
    check("R1 irOut", int'(irOut), 0);
    check("R1 capFlag", int'(capFlag), 0);
    for (int i = 0; i < 5; i++) begin
      rd(4'(11 + i), v);
      check("R1 capture value", v, 0);
    end
  endtask

  task automatic testReadback();
    int v;
    wr(4'd1, 16'h1234); rd(4'd1, v); check("R11 period", v, 16'h1234);
    wr(4'd4, 16'hBEEF); rd(4'd4, v); check("R11 compare2", v, 16'hBEEF);
    wr(4'd7, 16'hFFFF); rd(4'd7, v); check("R11 mode", v, 16'h7FFF);
    wr(4'd9, 16'hA55A); rd(4'd9, v); check("R11 carrier", v, 16'hA55A);
    wr(4'd0, 16'hFFE0); rd(4'd0, v); check("R11 control", v, 0);
    wr(4'd7, 16'h0000);
  endtask

  task automatic testPwm();
    int c;
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'd9);
    wr(4'd2, 16'd3);
    wr(4'd3, 16'd0);
    wr(4'd4, 16'd10);
    wr(4'd5, 16'd9);
    repeat (3) @(negedge clk);
    check("R4 disabled outputs", int'(chanOut), 0);
    wr(4'd0, 16'h0008);
    repeat (20) @(negedge clk);
    countHigh(0, 50, c); check("R3 cmp3 per9", c, 15);
    countHigh(1, 50, c); check("R3 cmp0 always low", c, 0);
    countHigh(2, 50, c); check("R3 cmp above period", c, 50);
    countHigh(3, 50, c); check("R3 cmp equals period", c, 45);
  endtask

  task automatic testPrescale();
    int c;
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'd4);
    wr(4'd2, 16'd2);
    wr(4'd0, 16'h000A);
    repeat (30) @(negedge clk);
    countHigh(0, 100, c); check("R2 divide by 4", c, 40);
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'd1);
    wr(4'd2, 16'd1);
    wr(4'd0, 16'h000F);
    repeat (40) @(negedge clk);
    countHigh(0, 512, c); check("R2 divide by 128", c, 256);
  endtask

  task automatic testBuffer();
    bit prev, cur;
    int c1, c2, guard;
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'd9);
    wr(4'd2, 16'd3);
    wr(4'd0, 16'h0008);
    prev = 1'b1; cur = 1'b1; guard = 0;
    while (!(cur && !prev) && guard < 40) begin
      prev = cur;
      @(negedge clk);
      cur = chanOut[0];
      guard++;
    end
    c1 = 0; c2 = 0;
    for (int k = 0; k < 20; k++) begin
      if (k > 0) @(negedge clk);
      if (chanOut[0]) begin
        if (k < 10) c1++; else c2++;
      end
      if (k == 0) begin
        regWe = 1'b1; regAddr = 4'd2; regWdata = 16'd7;
      end else begin
        regWe = 1'b0;
      end
    end
    check("R5 current period keeps old duty", c1, 3);
    check("R5 next period uses new duty", c2, 7);
  endtask

  task automatic testModes();
    int c, v;
    wr(4'd7, 16'h0001);
    repeat (10) @(negedge clk);
    countHigh(0, 30, c); check("R4 capture-mode channel low", c, 0);
    @(negedge clk); capIn[0] = 1'b1;
    repeat (3) @(negedge clk); capIn[0] = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 no edge selected, flag0", int'(capFlag[0]), 0);
    capIn[1] = 1'b1;
    repeat (3) @(negedge clk); capIn[1] = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 PWM channel flag1", int'(capFlag[1]), 0);
    rd(4'd12, v); check("R10 PWM channel value", v, 0);
  endtask

  task automatic testCapture();
    int v1, v2, v;
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'd199);
    wr(4'd7, 16'h7AD8);
    wr(4'd0, 16'h0008);
    repeat (25) @(negedge clk);
    capIn[1] = 1'b1;
    repeat (17) @(negedge clk);
    capIn[2] = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'd12, v1); rd(4'd13, v2);
    check("R8 rising capture spacing", v2, (v1 + 17) % 200);
    check("R9 flags 1 and 2 set", int'(capFlag), 5'b00110);
    capIn[3] = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 falling mode ignores rise", int'(capFlag[3]), 0);
    capIn[3] = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 falling mode captures fall", int'(capFlag[3]), 1);
    capIn[4] = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 both mode rise", int'(capFlag[4]), 1);
    wr(4'd10, 16'h0010);
    check("R9 clear only flag4", int'(capFlag), 5'b01110);
    rd(4'd10, v); check("R11 flag readback", v, 5'b01110);
    capIn[4] = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 both mode fall", int'(capFlag[4]), 1);
    @(negedge clk);
    regWe = 1'b1; regAddr = 4'd10; regWdata = 16'h0010; capIn[4] = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    check("R9 capture wins over clear", int'(capFlag[4]), 1);
    wr(4'd10, 16'h001F);
    check("R9 clear all", int'(capFlag), 0);
    capIn = '0;
    repeat (2) @(negedge clk);
    wr(4'd10, 16'h001F);
  endtask

  task automatic testCarrier();
    int c;
    wr(4'd7, 16'h0000);
    wr(4'd0, 16'h0000);
    wr(4'd1, 16'd4);
    wr(4'd2, 16'd2);
    wr(4'd9, 16'h0103);
    wr(4'd8, 16'h0009);
    wr(4'd0, 16'h0008);
    repeat (20) @(negedge clk);
    countHigh(5, 80, c); check("R6 carrier duty", c, 20);
    countHigh(6, 80, c); check("R7 irOut low outside IR mode", c, 0);
    wr(4'd0, 16'h0000);
    wr(4'd0, 16'h0018);
    repeat (45) @(negedge clk);
    countHigh(0, 200, c); check("R7 main counts carrier periods", c, 80);
    countHigh(6, 200, c); check("R7 modulated output", c, 20);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadback();
    testPwm();
    testPrescale();
    testBuffer();
    testModes();
    testCapture();
    testCarrier();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule